// File: doc/BRIEF.md
# Privileged capability register bank

This block keeps the eight special capability registers that sit beside the general capability file: the default data capability, the user and privileged thread-local capabilities, two registers reserved for the kernel, the kernel code and kernel data capabilities, and the exception program counter capability. A 5-bit hardware-register selector addresses them for move-from reads and move-to writes. Selectors outside the map are rejected, and the kernel-only entries need system-register permission from the current program capability.

The bank also carries the exception sequencing. On exception entry it saves the current program capability, re-based at the faulting pc, into the exception register. It then redirects the next and the delayed program capabilities together to the kernel code capability and presents the kernel code base as the vector base. On exception return both program capabilities are reloaded from the exception register.

A capability is a packed vector of 1+3*AW bits: tag in the top bit, then base, then length, then offset in the low AW bits. The null capability is all zero. The default capability has the tag set, base 0, length all ones and offset 0.

Top module: `spec_cap_bank`

## Requirements
- R1: With rd_en high, a valid selector and sufficient privilege, rd_cap shows the addressed register in the same cycle. The valid selectors are 0 default data, 1 user thread-local, 8 privileged thread-local, 22 and 23 kernel-reserved, 29 kernel code, 30 kernel data and 31 exception capability. In every other case rd_cap is null.
- R2: Any other selector with rd_en or wr_en high raises bad_sel and never changes a register.
- R3: After reset, selectors 0, 29 and 31 hold the default capability and selectors 1, 8, 22, 23 and 30 hold null. The next and delayed program capabilities hold the default capability.
- R4: Selectors 22, 23, 29, 30 and 31 need sys_perm. Access without it raises priv_fault, leaves the bank unchanged and reports the selector on fault_sel, which is 0 when no fault is raised. Selectors 0, 1 and 8 work in any mode.
- R5: A permitted move-to write is visible on the next cycle.
- R6: On exc_entry with exc_pc no greater than the length field of pcc, the exception register becomes pcc with its offset replaced by exc_pc.
- R7: On exc_entry with exc_pc greater than that length, the exception register becomes untagged, with base and length 0 and offset equal to pcc base plus exc_pc modulo 2^AW.
- R8: exc_entry loads next_pcc and delayed_pcc with the kernel code capability as it stood before the edge. vector_base always shows the kernel code base.
- R9: exc_return without exc_entry loads next_pcc and delayed_pcc with the exception register as it stood before the edge.
- R10: exc_entry wins over a move-to write and over exc_return in the same cycle. The write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 5 | Hardware-register selector |
| rd_en | input | 1 | Move-from request |
| wr_en | input | 1 | Move-to request |
| wr_cap | input | 1+3*AW | Capability to write |
| sys_perm | input | 1 | Program capability grants system-register access |
| rd_cap | output | 1+3*AW | Read data |
| bad_sel | output | 1 | Selector not in map |
| priv_fault | output | 1 | Access-system-registers violation |
| fault_sel | output | 5 | Selector reported with a fault |
| exc_entry | input | 1 | Exception entry |
| exc_pc | input | AW | Faulting pc |
| pcc | input | 1+3*AW | Current program capability |
| exc_return | input | 1 | Exception return |
| next_pcc | output | 1+3*AW | Next program capability |
| delayed_pcc | output | 1+3*AW | Delayed program capability |
| vector_base | output | AW | Exception vector base |

## Verification
The bench builds the bank with AW set to 8, which makes a capability 25 bits wide. At that width the sum of pcc base and exc_pc overflows with small operands, so the modulo wrap in the unrepresentable case is exercised. The boundary where exc_pc equals the length and the case one above it are both reached with short vectors. All 32 selector values are swept with and without permission, so every gap in the sparse map is covered.

// File: rtl/spec_cap_bank.sv
module spec_cap_bank #(
  parameter int AW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4:0]         sel,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [3*AW:0]      wr_cap,
  input  logic               sys_perm,
  output logic [3*AW:0]      rd_cap,
  output logic               bad_sel,
  output logic               priv_fault,
  output logic [4:0]         fault_sel,
  input  logic               exc_entry,
  input  logic [AW-1:0]      exc_pc,
  input  logic [3*AW:0]      pcc,
  input  logic               exc_return,
  output logic [3*AW:0]      next_pcc,
  output logic [3*AW:0]      delayed_pcc,
  output logic [AW-1:0]      vector_base
);
  localparam int CW = 1 + 3*AW;
  localparam logic [CW-1:0] NULL_CAP = '0;
  localparam logic [CW-1:0] DFLT_CAP = {1'b1, {AW{1'b0}}, {AW{1'b1}}, {AW{1'b0}}};
  localparam int KCC_SLOT = 5;
  localparam int EPC_SLOT = 7;

  logic [CW-1:0] bank [8];
  logic [2:0]    slot;
  logic          hit;

  always_comb begin
    hit  = 1'b1;
    slot = 3'd0;
    case (sel)
      5'd0:    slot = 3'd0;
      5'd1:    slot = 3'd1;
      5'd8:    slot = 3'd2;
      5'd22:   slot = 3'd3;
      5'd23:   slot = 3'd4;
      5'd29:   slot = 3'd5;
      5'd30:   slot = 3'd6;
      5'd31:   slot = 3'd7;
      default: hit  = 1'b0;
    endcase
  end

  wire locked = hit && (slot >= 3'd3) && !sys_perm;
  wire access = rd_en || wr_en;
  assign bad_sel    = access && !hit;
  assign priv_fault = access && locked;
  assign fault_sel  = (bad_sel || priv_fault) ? sel : 5'd0;
  assign rd_cap     = (rd_en && hit && !locked) ? bank[slot] : NULL_CAP;
  wire wr_ok = wr_en && hit && !locked && !exc_entry;

  wire [AW-1:0] p_base = pcc[3*AW-1:2*AW];
  wire [AW-1:0] p_len  = pcc[2*AW-1:AW];
  wire          fits   = exc_pc <= p_len;
  wire [AW-1:0] p_sum  = p_base + exc_pc;
  wire [CW-1:0] saved  = fits ? {pcc[CW-1:AW], exc_pc} : {1'b0, {(2*AW){1'b0}}, p_sum};

  assign vector_base = bank[KCC_SLOT][3*AW-1:2*AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++)
        bank[i] <= (i == 0 || i == KCC_SLOT || i == EPC_SLOT) ? DFLT_CAP : NULL_CAP;
      next_pcc    <= DFLT_CAP;
      delayed_pcc <= DFLT_CAP;
    end else if (exc_entry) begin
      bank[EPC_SLOT] <= saved;
      next_pcc       <= bank[KCC_SLOT];
      delayed_pcc    <= bank[KCC_SLOT];
    end else begin
      if (wr_ok) bank[slot] <= wr_cap;
      if (exc_return) begin
        next_pcc    <= bank[EPC_SLOT];
        delayed_pcc <= bank[EPC_SLOT];
      end
    end
  end
endmodule

// File: rtl/spec_cap_bank_chk.sv
module spec_cap_bank_chk #(
  parameter int AW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:0]      sel,
  input logic            wr_en,
  input logic            bad_sel,
  input logic            priv_fault,
  input logic            exc_entry,
  input logic            exc_return,
  input logic [3*AW:0]   next_pcc,
  input logic [3*AW:0]   delayed_pcc,
  input logic [3*AW:0]   kcc,
  input logic [3*AW:0]   epcc,
  input logic [3*AW:0]   ddc,
  input logic [8*(3*AW+1)-1:0] snap
);
  p_bad_sel_keeps_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sel && !exc_entry |=> $stable(snap));
  p_priv_keeps_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault && !exc_entry |=> $stable(snap));
  p_fault_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bad_sel && priv_fault));
  p_entry_loads_kcc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> (next_pcc == $past(kcc)) && (delayed_pcc == $past(kcc)));
  p_pcs_paired_r8: assert property (@(posedge clk) disable iff (!rst_n)
    next_pcc == delayed_pcc);
  p_return_loads_epcc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_return && !exc_entry |=> (next_pcc == $past(epcc)) && (delayed_pcc == $past(epcc)));
  p_entry_beats_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry && wr_en && sel == 5'd0 |=> $stable(ddc));
endmodule

bind spec_cap_bank spec_cap_bank_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
  .bad_sel(bad_sel), .priv_fault(priv_fault),
  .exc_entry(exc_entry), .exc_return(exc_return),
  .next_pcc(next_pcc), .delayed_pcc(delayed_pcc),
  .kcc(bank[5]), .epcc(bank[7]), .ddc(bank[0]),
  .snap({bank[7], bank[6], bank[5], bank[4], bank[3], bank[2], bank[1], bank[0]})
);

// File: tb/spec_cap_bank_bench.sv
module spec_cap_bank_bench;
  localparam int AW = 8;
  localparam int CW = 1 + 3*AW;
  localparam logic [CW-1:0] NULLV = '0;
  localparam logic [CW-1:0] DFLTV = {1'b1, 8'h00, 8'hFF, 8'h00};

  logic clk = 0, rst_n = 0;
  logic [4:0] sel = 0;
  logic rd_en = 0, wr_en = 0, sys_perm = 0, exc_entry = 0, exc_return = 0;
  logic [CW-1:0] wr_cap = 0, pcc = 0;
  logic [AW-1:0] exc_pc = 0;
  logic [CW-1:0] rd_cap, next_pcc, delayed_pcc;
  logic bad_sel, priv_fault;
  logic [4:0] fault_sel;
  logic [AW-1:0] vector_base;

  int n_chk = 0, n_fail = 0;
  logic [CW-1:0] m [32];
  logic [CW-1:0] m_nxt, m_dly;

  always #2 clk = ~clk;

  spec_cap_bank #(.AW(AW)) u_spec_cap_bank (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_cap(wr_cap), .sys_perm(sys_perm), .rd_cap(rd_cap), .bad_sel(bad_sel),
    .priv_fault(priv_fault), .fault_sel(fault_sel), .exc_entry(exc_entry),
    .exc_pc(exc_pc), .pcc(pcc), .exc_return(exc_return), .next_pcc(next_pcc),
    .delayed_pcc(delayed_pcc), .vector_base(vector_base)
  );

  function automatic bit known(input int s);
    return s == 0 || s == 1 || s == 8 || s == 22 || s == 23 || s == 29 || s == 30 || s == 31;
  endfunction

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m[i] = NULLV;
    m[0] = DFLTV; m[29] = DFLTV; m[31] = DFLTV;
    m_nxt = DFLTV; m_dly = DFLTV;
  endtask

  task automatic compare();
    bit ok, acc, bad, pf;
    acc = rd_en || wr_en;
    ok  = known(sel);
    bad = acc && !ok;
    pf  = acc && ok && (sel >= 22) && !sys_perm;
    chk("R1 rd_cap", rd_cap, (rd_en && ok && !pf && !(!rd_en)) ? m[sel] :
        ((rd_en && ok && !((sel >= 22) && !sys_perm)) ? m[sel] : NULLV));
    chk("R2 bad_sel", CW'(bad_sel), CW'(bad));
    chk("R4 priv_fault", CW'(priv_fault), CW'(pf));
    chk("R4 fault_sel", CW'(fault_sel), (bad || pf) ? CW'(sel) : '0);
    chk("R8 next_pcc", next_pcc, m_nxt);
    chk("R8 delayed_pcc", delayed_pcc, m_dly);
    chk("R8 vector_base", CW'(vector_base), CW'(m[29][23:16]));
  endtask

  task automatic model_step();
    logic [CW-1:0] kc, ep;
    logic [AW-1:0] b, l;
    kc = m[29]; ep = m[31];
    b = pcc[23:16]; l = pcc[15:8];
    if (exc_entry) begin
      m[31] = (exc_pc <= l) ? {pcc[24:8], exc_pc} : {1'b0, 16'h0, AW'(b + exc_pc)};
      m_nxt = kc; m_dly = kc;
    end else begin
      if (wr_en && known(sel) && !((sel >= 22) && !sys_perm)) m[sel] = wr_cap;
      if (exc_return) begin m_nxt = ep; m_dly = ep; end
    end
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    rd_en = 0; wr_en = 0; exc_entry = 0; exc_return = 0;
  endtask

  task automatic rd(input int s, input bit p);
    idle(); sel = 5'(s); sys_perm = p; rd_en = 1; cyc();
  endtask

  task automatic wr(input int s, input bit p, input logic [CW-1:0] v);
    idle(); sel = 5'(s); sys_perm = p; wr_en = 1; wr_cap = v; cyc();
  endtask

  initial begin
    #150000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3 reset contents read back through every valid selector
    chk("R3 next_pcc reset", next_pcc, DFLTV);
    for (int s = 0; s < 32; s++) rd(s, 1);
    // R1 R5 write then read every valid selector
    for (int s = 0; s < 32; s++) if (known(s)) begin
      wr(s, 1, CW'(32'h0A5A000 + s * 77));
      rd(s, 1);
      chk("R5 write visible", rd_cap, CW'(32'h0A5A000 + s * 77));
    end
    // R2 invalid selectors never write
    for (int s = 0; s < 32; s++) if (!known(s)) wr(s, 1, CW'(32'h1FFFFFF));
    for (int s = 0; s < 32; s++) rd(s, 1);
    // R4 privilege rules
    for (int s = 0; s < 32; s++) wr(s, 0, CW'(32'h0123456));
    for (int s = 0; s < 32; s++) rd(s, 0);
    for (int s = 0; s < 32; s++) rd(s, 1);
    // R6 representable entry: pc equal to length
    wr(29, 1, {1'b1, 8'h40, 8'h20, 8'h03});
    idle(); pcc = {1'b1, 8'h10, 8'h30, 8'h05}; exc_pc = 8'h30; exc_entry = 1; cyc();
    rd(31, 1);
    chk("R6 saved epcc", rd_cap, {1'b1, 8'h10, 8'h30, 8'h30});
    chk("R8 vector", CW'(vector_base), CW'(8'h40));
    // R9 return
    idle(); exc_return = 1; cyc(); idle(); cyc();
    chk("R9 next_pcc", next_pcc, {1'b1, 8'h10, 8'h30, 8'h30});
    // R7 unrepresentable with wrap
    idle(); pcc = {1'b1, 8'hF0, 8'h10, 8'h00}; exc_pc = 8'h20; exc_entry = 1; cyc();
    rd(31, 1);
    chk("R7 untagged epcc", rd_cap, {1'b0, 16'h0, 8'h10});
    idle(); pcc = {1'b1, 8'hF0, 8'h10, 8'h00}; exc_pc = 8'h11; exc_entry = 1; cyc();
    rd(31, 1);
    chk("R7 length+1", rd_cap, {1'b0, 16'h0, 8'h01});
    // R10 entry beats write and return
    idle(); sel = 0; sys_perm = 1; wr_en = 1; wr_cap = CW'(32'h0777777);
    exc_entry = 1; exc_return = 1; exc_pc = 8'h02; cyc();
    rd(0, 1);
    chk("R10 write dropped", rd_cap == CW'(32'h0777777) ? 1 : 0, 0);
    chk("R10 next is kcc", next_pcc, {1'b1, 8'h40, 8'h20, 8'h03});
    for (int k = 0; k < 40; k++) begin
      idle(); sel = 5'(k * 7); sys_perm = k[0]; rd_en = k[1]; wr_en = k[2];
      wr_cap = CW'(k * 12345); exc_entry = (k % 5 == 0); exc_return = (k % 3 == 0);
      pcc = CW'(k * 99991); exc_pc = 8'(k * 13); cyc();
    end
    idle(); cyc();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule